// File: doc/BRIEF.md
# Clamped Video Gain Converter

This block takes three digitally clamped 9-bit component channels and turns them into 8-bit samples. Each sample has the clamp level subtracted from it, so a sample sitting exactly at the clamp level lands on output code 0. A per-channel gain numerator over 64 then stretches the content above the clamp level to fill the 8-bit range. Channel 0 carries luma (Y) in YCbCr mode and green (G) in RGB mode. Channels 1 and 2 carry Cb/B and Cr/R.

A colour-space mode input sets the base of the channel 0 gain. In YCbCr mode it also enables a sync-retain option for luma. An optional nonlinear mode doubles the gain near black, up to a programmable knee. Above the knee the linear slope resumes from the knee output point.

Each input sample is qualified by a valid strobe. Results appear on registered outputs exactly one clock later and hold while no new valid sample arrives. Clamp-level tracking is done upstream, and the clamp level is an input here.

Top module: `clamped_gain_conv`

## Requirements
- R1: `valid_o` follows `valid_i` with one clock of latency. The three outputs update only on a clock where `valid_i` was 1, and otherwise they hold their value.
- R2: In YCbCr mode (`rgb_mode_i`=0), the channel 0 gain is (32+`gain0_i`)/64. Every channel result is floor((d·G+32)/64), where d is the sample minus `clamp_lvl_i` and G is the gain numerator.
- R3: In RGB mode (`rgb_mode_i`=1), the channel 0 gain is (48+`gain0_i`)/64.
- R4: Channel 1 uses (48+`gain1_i`)/64 and channel 2 uses (48+`gain2_i`)/64, in both modes.
- R5: With sync cut (`sync_keep_i`=0, or any chroma channel, or RGB mode), a sample at or below the clamp level gives output 0.
- R6: In YCbCr mode with `sync_keep_i`=1, channel 0 adds a footroom of 16 to the rounded result. Below-clamp samples then scale down towards 0 instead of being cut.
- R7: In RGB mode, `sync_keep_i` has no effect on any output.
- R8: With `nonlin_i`=1 and 0 ≤ d < K, where K = 4·`knee_ofs_i`, the product is 2·d·G.
- R9: With `nonlin_i`=1 and d ≥ K, the product is (d+K)·G. This continues from the knee point at the linear slope.
- R10: Results above 255 saturate to 255, and results below 0 saturate to 0.
- R11: During reset, `valid_o` and all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Input sample strobe |
| c0_i | input | 9 | Channel 0 sample (Y or G) |
| c1_i | input | 9 | Channel 1 sample (Cb or B) |
| c2_i | input | 9 | Channel 2 sample (Cr or R) |
| clamp_lvl_i | input | 9 | Clamp level shared by all channels |
| rgb_mode_i | input | 1 | 0 = YCbCr, 1 = RGB |
| sync_keep_i | input | 1 | 1 = keep luma sync with footroom, 0 = cut |
| nonlin_i | input | 1 | 1 = nonlinear gain with knee |
| knee_ofs_i | input | 5 | Knee position, in steps of 4 codes above clamp |
| gain0_i | input | 7 | Channel 0 gain adjust |
| gain1_i | input | 7 | Channel 1 gain adjust |
| gain2_i | input | 7 | Channel 2 gain adjust |
| valid_o | output | 1 | Output strobe |
| c0_o | output | 8 | Channel 0 result |
| c1_o | output | 8 | Channel 1 result |
| c2_o | output | 8 | Channel 2 result |

## Verification
A wrong gain base, knee or rounding offset shows up in a single output code, one clock after the offending sample. Any sweep of the full 9-bit input range therefore exposes it within one pass. A footroom enable leaking into RGB mode or into the chroma channels lifts the clamp-level output off 0 on the very next valid sample. A broken hold path changes an output on a clock where `valid_i` was low, and this is visible immediately.

// File: rtl/cvg_pkg.sv
package cvg_pkg;
  localparam int DIN_W      = 9;
  localparam int DOUT_W     = 8;
  localparam int GAIN_W     = 7;
  localparam int KNEE_W     = 5;
  localparam int FRAC_W     = 6;
  localparam int KNEE_SHIFT = 2;
  localparam int SYNC_FOOT  = 16;
  localparam int BASE_LUMA  = 32;
  localparam int BASE_WIDE  = 48;
  localparam int NCH        = 3;

  // Scale a clamp-relative difference by gnum/2^frac with optional knee.
  function automatic int cvg_scale(input int d, input int gnum, input bit nonlin,
                                   input int knee, input int foot, input int frac,
                                   input int omax);
    int p;
    int r;
    if (d < 0)                     p = d * gnum;
    else if (nonlin && (d < knee)) p = 2 * d * gnum;
    else if (nonlin)               p = (d + knee) * gnum;
    else                           p = d * gnum;
    r = (p + (1 << (frac - 1))) >>> frac;
    r = r + foot;
    if (r < 0)    r = 0;
    if (r > omax) r = omax;
    return r;
  endfunction
endpackage

// File: rtl/cvg_gain_sel.sv
module cvg_gain_sel #(
  parameter int GAIN_W = cvg_pkg::GAIN_W,
  parameter int NCH    = cvg_pkg::NCH,
  localparam int GN_W  = GAIN_W + 2
) (
  input  logic                          rgb_mode_i,
  input  logic                          sync_keep_i,
  input  logic [NCH-1:0][GAIN_W-1:0]    gain_i,
  output logic [NCH-1:0][GN_W-1:0]      gnum_o,
  output logic [NCH-1:0]                foot_en_o,
  output logic [NCH-1:0]                cut_en_o
);
  logic luma_keep;
  assign luma_keep = sync_keep_i & ~rgb_mode_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == 0) begin : g_luma
      assign gnum_o[c]    = GN_W'(rgb_mode_i ? cvg_pkg::BASE_WIDE : cvg_pkg::BASE_LUMA)
                            + GN_W'(gain_i[c]);
      assign foot_en_o[c] = luma_keep;
    end else begin : g_chroma
      assign gnum_o[c]    = GN_W'(cvg_pkg::BASE_WIDE) + GN_W'(gain_i[c]);
      assign foot_en_o[c] = 1'b0;
    end
    assign cut_en_o[c] = ~foot_en_o[c];
  end
endmodule

// File: rtl/cvg_channel.sv
module cvg_channel #(
  parameter int DIN_W  = cvg_pkg::DIN_W,
  parameter int DOUT_W = cvg_pkg::DOUT_W,
  parameter int GN_W   = cvg_pkg::GAIN_W + 2,
  parameter int KNEE_W = cvg_pkg::KNEE_W,
  localparam int OMAX  = (1 << DOUT_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIN_W-1:0]  sample_i,
  input  logic [DIN_W-1:0]  clamp_i,
  input  logic [GN_W-1:0]   gnum_i,
  input  logic              nonlin_i,
  input  logic [KNEE_W-1:0] knee_i,
  input  logic              foot_en_i,
  input  logic              cut_en_i,
  output logic [DOUT_W-1:0] result_o,
  output logic              below_o
);
  int diff_raw;
  int diff_eff;
  int knee;
  int scaled;

  always_comb begin
    diff_raw = int'(sample_i) - int'(clamp_i);
    diff_eff = (cut_en_i && diff_raw < 0) ? 0 : diff_raw;
    knee     = int'(knee_i) << cvg_pkg::KNEE_SHIFT;
    scaled   = cvg_pkg::cvg_scale(diff_eff, int'(gnum_i), nonlin_i, knee,
                                  foot_en_i ? cvg_pkg::SYNC_FOOT : 0,
                                  cvg_pkg::FRAC_W, OMAX);
    result_o = scaled[DOUT_W-1:0];
  end
  assign below_o = (sample_i <= clamp_i);

  // Cut sync: at/below clamp the result is black.
  assert_cut_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_en_i && below_o) |-> (result_o == '0));
  // Footroom: at or above clamp the result never drops under the foot.
  assert_foot_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (foot_en_i && sample_i >= clamp_i) |-> (result_o >= DOUT_W'(cvg_pkg::SYNC_FOOT)));
endmodule

// File: rtl/clamped_gain_conv.sv
module clamped_gain_conv #(
  parameter int DIN_W  = cvg_pkg::DIN_W,
  parameter int DOUT_W = cvg_pkg::DOUT_W,
  parameter int GAIN_W = cvg_pkg::GAIN_W,
  parameter int KNEE_W = cvg_pkg::KNEE_W,
  localparam int NCH   = cvg_pkg::NCH,
  localparam int GN_W  = GAIN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DIN_W-1:0]  c0_i,
  input  logic [DIN_W-1:0]  c1_i,
  input  logic [DIN_W-1:0]  c2_i,
  input  logic [DIN_W-1:0]  clamp_lvl_i,
  input  logic              rgb_mode_i,
  input  logic              sync_keep_i,
  input  logic              nonlin_i,
  input  logic [KNEE_W-1:0] knee_ofs_i,
  input  logic [GAIN_W-1:0] gain0_i,
  input  logic [GAIN_W-1:0] gain1_i,
  input  logic [GAIN_W-1:0] gain2_i,
  output logic              valid_o,
  output logic [DOUT_W-1:0] c0_o,
  output logic [DOUT_W-1:0] c1_o,
  output logic [DOUT_W-1:0] c2_o
);
  logic [NCH-1:0][DIN_W-1:0]  samples;
  logic [NCH-1:0][GAIN_W-1:0] gains;
  logic [NCH-1:0][GN_W-1:0]   gnum;
  logic [NCH-1:0]             foot_en;
  logic [NCH-1:0]             cut_en;
  logic [NCH-1:0]             below;
  logic [NCH-1:0][DOUT_W-1:0] comb_res;
  logic [NCH-1:0][DOUT_W-1:0] out_q;

  assign samples = {c2_i, c1_i, c0_i};
  assign gains   = {gain2_i, gain1_i, gain0_i};

  cvg_gain_sel #(.GAIN_W(GAIN_W), .NCH(NCH)) u_sel (
    .rgb_mode_i (rgb_mode_i),
    .sync_keep_i(sync_keep_i),
    .gain_i     (gains),
    .gnum_o     (gnum),
    .foot_en_o  (foot_en),
    .cut_en_o   (cut_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    cvg_channel #(.DIN_W(DIN_W), .DOUT_W(DOUT_W), .GN_W(GN_W), .KNEE_W(KNEE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (samples[c]),
      .clamp_i  (clamp_lvl_i),
      .gnum_i   (gnum[c]),
      .nonlin_i (nonlin_i),
      .knee_i   (knee_ofs_i),
      .foot_en_i(foot_en[c]),
      .cut_en_i (cut_en[c]),
      .result_o (comb_res[c]),
      .below_o  (below[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)       out_q[c] <= '0;
      else if (valid_i) out_q[c] <= comb_res[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_i;
  end

  assign c0_o = out_q[0];
  assign c1_o = out_q[1];
  assign c2_o = out_q[2];

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(c0_o) && $stable(c1_o) && $stable(c2_o)));
  assert_rgb_no_foot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_mode_i |-> (foot_en == '0));
  assert_chroma_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (below[1] |-> comb_res[1] == '0) and (below[2] |-> comb_res[2] == '0));
endmodule

// File: tb/clamped_gain_conv_tb_top.sv
module clamped_gain_conv_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [8:0] c0_i = '0, c1_i = '0, c2_i = '0, clamp_lvl_i = '0;
  logic rgb_mode_i = 1'b0, sync_keep_i = 1'b0, nonlin_i = 1'b0;
  logic [4:0] knee_ofs_i = '0;
  logic [6:0] gain0_i = '0, gain1_i = '0, gain2_i = '0;
  logic valid_o;
  logic [7:0] c0_o, c1_o, c2_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  clamped_gain_conv dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .c0_i(c0_i), .c1_i(c1_i), .c2_i(c2_i), .clamp_lvl_i(clamp_lvl_i),
    .rgb_mode_i(rgb_mode_i), .sync_keep_i(sync_keep_i), .nonlin_i(nonlin_i),
    .knee_ofs_i(knee_ofs_i), .gain0_i(gain0_i), .gain1_i(gain1_i), .gain2_i(gain2_i),
    .valid_o(valid_o), .c0_o(c0_o), .c1_o(c1_o), .c2_o(c2_o)
  );

  // Reference written from the requirements: effective distance times gain.
  function automatic int ref_out(int s, int clamp, int g, int base, bit nl, int ofs, bit foot);
    int d, eff, k, q, r;
    d = s - clamp;
    k = ofs * 4;
    if (!foot && d < 0) d = 0;
    if (nl && d >= 0) eff = (d < k) ? 2 * d : d + k;
    else              eff = d;
    q = eff * (base + g) + 32;
    r = (q >= 0) ? q / 64 : -((-q + 63) / 64);
    if (foot) r = r + 16;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string pick_tag(int ch, int s, int clamp, bit rgb, bit keep, bit nl,
                                     int ofs, int e);
    int d;
    d = s - clamp;
    if (e == 255) return "R10";
    if (ch == 0 && rgb && keep) return "R7";
    if (ch == 0 && !rgb && keep) return "R6";
    if (d <= 0) return "R5";
    if (nl) return (d < ofs * 4) ? "R8" : "R9";
    if (ch != 0) return "R4";
    return rgb ? "R3" : "R2";
  endfunction

  task automatic sweep(bit rgb, bit keep, bit nl, int ofs, int g0, int g1, int g2, int clamp);
    rgb_mode_i = rgb; sync_keep_i = keep; nonlin_i = nl;
    knee_ofs_i = 5'(ofs); gain0_i = 7'(g0); gain1_i = 7'(g1); gain2_i = 7'(g2);
    clamp_lvl_i = 9'(clamp);
    for (int s = 0; s < 512; s++) begin
      int s1, s2, e0, e1, e2;
      s1 = (s + 171) % 512;
      s2 = (s + 341) % 512;
      c0_i = 9'(s); c1_i = 9'(s1); c2_i = 9'(s2); valid_i = 1'b1;
      @(negedge clk);
      e0 = ref_out(s,  clamp, g0, rgb ? 48 : 32, nl, ofs, !rgb && keep);
      e1 = ref_out(s1, clamp, g1, 48, nl, ofs, 1'b0);
      e2 = ref_out(s2, clamp, g2, 48, nl, ofs, 1'b0);
      check(pick_tag(0, s,  clamp, rgb, keep, nl, ofs, e0), int'(c0_o), e0);
      check(pick_tag(1, s1, clamp, rgb, keep, nl, ofs, e1), int'(c1_o), e1);
      check(pick_tag(2, s2, clamp, rgb, keep, nl, ofs, e2), int'(c2_o), e2);
      check("R1 valid", int'(valid_o), 1);
    end
  endtask

  initial begin
    int h0, h1, h2;
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 valid", int'(valid_o), 0);
    check("R11 c0", int'(c0_o), 0);
    check("R11 c1", int'(c1_o), 0);
    check("R11 c2", int'(c2_o), 0);
    rst_n = 1'b1;

    sweep(0, 0, 0, 0,   0,   0,   0,  64);
    sweep(0, 0, 0, 0, 127, 127, 127,  32);
    sweep(1, 0, 0, 0,  16,   5, 100,  40);
    sweep(0, 1, 0, 0,  32,  10,  20, 100);
    sweep(1, 1, 0, 0,  32,  10,  20, 100);
    sweep(0, 0, 1, 31, 20,   0,  60,  50);
    sweep(0, 0, 1, 5,   0,  64,  16,   0);
    sweep(0, 1, 1, 10, 40,  40,  40, 200);
    sweep(1, 1, 1, 7,   3,  90,  33,  16);

    // R1: hold while valid_i is low, strobe falls after one clock
    h0 = int'(c0_o); h1 = int'(c1_o); h2 = int'(c2_o);
    valid_i = 1'b0;
    c0_i = 9'd3; c1_i = 9'd77; c2_i = 9'd400; gain0_i = 7'd99;
    @(negedge clk);
    check("R1 valid low", int'(valid_o), 0);
    for (int i = 0; i < 4; i++) begin
      c0_i = 9'(i * 100); c1_i = 9'(511 - i);
      @(negedge clk);
      check("R1 hold c0", int'(c0_o), h0);
      check("R1 hold c1", int'(c1_o), h1);
      check("R1 hold c2", int'(c2_o), h2);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule